// File: doc/BRIEF.md
# Fault Protection Hiccup Supervisor

This block sits between the analog fault comparators of a switching power controller and its gate driver, and decides on every clock whether the power switch may be driven. It sees digital flags for output under-voltage, output over-voltage, supply over-voltage, over-current and maximum duty. It also sees a strobe that marks each switching cycle, a digitised supply-voltage code and a digitised die-temperature code. Each fault has its own qualification rule. Under-voltage and maximum duty must persist for a long run of consecutive switching cycles. Over-current must persist for a short run. Output over-voltage, supply over-voltage and over-temperature act at once.

When any qualified fault appears, the block drops the gate enable and waits for a programmable number of switching strobes. It then tries one restart. Nothing latches, so the converter keeps hiccuping until the condition is gone. Undervoltage lockout and over-temperature use hysteresis. A sticky cause register keeps the code of the first fault that tripped until software clears it or the block is reset.

Top module: `hiccup_supervisor`

## Requirements
- R1: An under-voltage flag trips the supervisor only on the LONG_DEB-th consecutive switching strobe during which it is high (default 2048, counted by an 11-bit counter). The gate enable is low from the clock after that strobe.
- R2: A maximum-duty flag trips after the same LONG_DEB consecutive strobes as R1.
- R3: An over-current flag trips after OC_DEB consecutive strobes (default 4). With one strobe fewer, the gate stays enabled.
- R4: An output over-voltage flag or a supply over-voltage flag drops the gate enable on the next clock, without waiting for any strobe.
- R5: Lockout applies from reset. The gate enable can rise only after supplyCode exceeds ON_CODE (default 145). Once running, the gate is forced low only after supplyCode falls below OFF_CODE (default 85). Codes between the two thresholds keep the current lockout state.
- R6: Over-temperature trips when tempCode reaches OTP_TRIP (default 150). It stays active until tempCode falls to OTP_TRIP minus OTP_HYS (default 120) or lower, and while active it acts as an instant fault.
- R7: After a trip, the gate stays low for hiccupLen switching strobes (a value of 0 counts as 1), and then one restart is attempted. If the condition persists, the block trips again. Once the condition is gone, the gate remains enabled.
- R8: A debounce counter restarts from zero whenever its flag is low on any clock, and while the gate is held off. A run that is broken by even one low strobe does not trip.
- R9: faultCause records the code of the first trip: 1 under-voltage, 2 output over-voltage, 3 supply over-voltage, 4 over-current, 5 maximum duty, 6 over-temperature. For simultaneous trips the priority is 3 > 2 > 4 > 6 > 1 > 5. A nonzero code is held through later trips.
- R10: A one-clock pulse on causeClear returns faultCause to 0, so that the next trip is recorded.
- R11: After reset, gateEnable is 0 and faultCause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycleStrobe | input | 1 | One-clock pulse per switching cycle |
| uvFlag | input | 1 | Output under-voltage comparator flag |
| ovFlag | input | 1 | Output over-voltage comparator flag |
| vddOvFlag | input | 1 | Supply over-voltage comparator flag |
| ocFlag | input | 1 | Over-current (shorted rectifier) flag |
| maxDutyFlag | input | 1 | Switch on-time reached maximum duty |
| supplyCode | input | SUP_W (8) | Digitised supply voltage |
| tempCode | input | TEMP_W (8) | Digitised die temperature |
| hiccupLen | input | HIC_W (8) | Off time of a hiccup, in strobes |
| causeClear | input | 1 | Clears the sticky cause register |
| gateEnable | output | 1 | Permission for the gate driver |
| faultCause | output | 3 | Code of the first fault (R9) |

## Verification
The bench builds the block with LONG_DEB set to 64, and keeps OC_DEB at 4 and every threshold at its default. At this setting, the exact boundary of the long debounce, one strobe short and exactly on count, can be reached many times within the cycle budget. Random run lengths straddle that boundary, and random hiccup lengths from 1 to 6 exercise the restart counter. Directed cases cover the hysteresis bands of lockout and temperature, retries while a fault is still present, and the cause priority.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    ST_LOCK = 2'd0,
    ST_RUN  = 2'd1,
    ST_OFF  = 2'd2
  } sup_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadHiccup;
    logic countHiccup;
    logic clearDebounce;
  } ctl_s;

  // qualified fault conditions from datapath to control
  typedef struct packed {
    logic vddOv;
    logic ov;
    logic oc;
    logic hot;
    logic uv;
    logic maxDuty;
  } trip_s;

  localparam int CAUSE_W = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_UV    = 3'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_OV    = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VDDOV = 3'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_OC    = 3'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_MAXD  = 3'd5;
  localparam logic [CAUSE_W-1:0] CAUSE_HOT   = 3'd6;

  // priority encoder: supply-ov > ov > oc > hot > uv > max duty
  function automatic logic [CAUSE_W-1:0] encodeCause(input trip_s t);
    if (t.vddOv)        return CAUSE_VDDOV;
    else if (t.ov)      return CAUSE_OV;
    else if (t.oc)      return CAUSE_OC;
    else if (t.hot)     return CAUSE_HOT;
    else if (t.uv)      return CAUSE_UV;
    else if (t.maxDuty) return CAUSE_MAXD;
    else                return CAUSE_NONE;
  endfunction

  function automatic logic anyTrip(input trip_s t);
    return |t;
  endfunction

endpackage

// File: rtl/hiccup_debounce.sv
module hiccup_debounce #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic flag,
  input  logic clear,
  output logic trip
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear || !flag) begin
      cnt <= '0;
    end else if (strobe && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  // trips on the LIMIT-th consecutive strobe with the flag high
  assign trip = flag && strobe && !clear && (cnt == LAST);

  // a low flag always restarts the run
  assert_clear_on_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag) |=> (cnt == '0));

  // counting advances by exactly one per qualifying strobe
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && strobe && !clear && cnt != LAST) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/hiccup_datapath.sv
module hiccup_datapath
  import hiccup_pkg::*;
#(
  parameter int LONG_DEB = 2048,
  parameter int OC_DEB   = 4,
  parameter int SUP_W    = 8,
  parameter int ON_CODE  = 145,
  parameter int OFF_CODE = 85,
  parameter int TEMP_W   = 8,
  parameter int OTP_TRIP = 150,
  parameter int OTP_HYS  = 30,
  parameter int HIC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycleStrobe,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              vddOvFlag,
  input  logic              ocFlag,
  input  logic              maxDutyFlag,
  input  logic [SUP_W-1:0]  supplyCode,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [HIC_W-1:0]  hiccupLen,
  input  ctl_s              ctl,
  output trip_s             trip,
  output logic              uvloOk,
  output logic              hiccupDone
);

  localparam logic [SUP_W-1:0]  ON_THR   = SUP_W'(ON_CODE);
  localparam logic [SUP_W-1:0]  OFF_THR  = SUP_W'(OFF_CODE);
  localparam logic [TEMP_W-1:0] HOT_SET  = TEMP_W'(OTP_TRIP);
  localparam logic [TEMP_W-1:0] HOT_REL  = TEMP_W'(OTP_TRIP - OTP_HYS);

  logic             hotState;
  logic [HIC_W-1:0] hicCnt;
  logic             uvTrip;
  logic             maxTrip;
  logic             ocTrip;

  // long debounce: under-voltage
  hiccup_debounce #(.LIMIT(LONG_DEB)) u_deb_uv (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cycleStrobe),
    .flag   (uvFlag),
    .clear  (ctl.clearDebounce),
    .trip   (uvTrip)
  );

  // long debounce: maximum duty
  hiccup_debounce #(.LIMIT(LONG_DEB)) u_deb_maxd (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cycleStrobe),
    .flag   (maxDutyFlag),
    .clear  (ctl.clearDebounce),
    .trip   (maxTrip)
  );

  // short debounce: over-current
  hiccup_debounce #(.LIMIT(OC_DEB)) u_deb_oc (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (cycleStrobe),
    .flag   (ocFlag),
    .clear  (ctl.clearDebounce),
    .trip   (ocTrip)
  );

  // undervoltage lockout with hysteresis
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uvloOk <= 1'b0;
    end else if (supplyCode > ON_THR) begin
      uvloOk <= 1'b1;
    end else if (supplyCode < OFF_THR) begin
      uvloOk <= 1'b0;
    end
  end

  // over-temperature with hysteresis
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hotState <= 1'b0;
    end else if (tempCode >= HOT_SET) begin
      hotState <= 1'b1;
    end else if (tempCode <= HOT_REL) begin
      hotState <= 1'b0;
    end
  end

  // hiccup off-time counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hicCnt <= '0;
    end else if (ctl.loadHiccup) begin
      hicCnt <= hiccupLen;
    end else if (ctl.countHiccup && hicCnt != '0) begin
      hicCnt <= hicCnt - 1'b1;
    end
  end

  assign hiccupDone = (hicCnt <= HIC_W'(1));

  always_comb begin
    trip         = '0;
    trip.uv      = uvTrip;
    trip.maxDuty = maxTrip;
    trip.oc      = ocTrip;
    trip.ov      = ovFlag;
    trip.vddOv   = vddOvFlag;
    trip.hot     = hotState;
  end

  assert_hot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hotState && tempCode > HOT_REL) |=> hotState);

  assert_uvlo_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (supplyCode <= ON_THR && supplyCode >= OFF_THR) |=> $stable(uvloOk));

endmodule

// File: rtl/hiccup_control.sv
module hiccup_control
  import hiccup_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cycleStrobe,
  input  logic               causeClear,
  input  trip_s              trip,
  input  logic               uvloOk,
  input  logic               hiccupDone,
  output ctl_s               ctl,
  output logic               gateEnable,
  output logic [CAUSE_W-1:0] faultCause
);

  sup_state_e          state;
  sup_state_e          stateNext;
  logic                tripNow;
  logic [CAUSE_W-1:0]  causeNext;

  assign tripNow = (state == ST_RUN) && uvloOk && anyTrip(trip);

  always_comb begin
    stateNext = state;
    if (!uvloOk) begin
      stateNext = ST_LOCK;
    end else begin
      unique case (state)
        ST_LOCK: stateNext = ST_RUN;
        ST_RUN:  if (anyTrip(trip)) stateNext = ST_OFF;
        ST_OFF:  if (cycleStrobe && hiccupDone) stateNext = ST_RUN;
        default: stateNext = ST_LOCK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_LOCK;
    else        state <= stateNext;
  end

  always_comb begin
    ctl.loadHiccup    = tripNow;
    ctl.countHiccup   = (state == ST_OFF) && cycleStrobe;
    ctl.clearDebounce = (state != ST_RUN);
  end

  // sticky first-fault cause
  always_comb begin
    causeNext = causeClear ? CAUSE_NONE : faultCause;
    if (causeNext == CAUSE_NONE && tripNow) causeNext = encodeCause(trip);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) faultCause <= CAUSE_NONE;
    else        faultCause <= causeNext;
  end

  assign gateEnable = (state == ST_RUN);

  assert_lockout_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!uvloOk) |=> !gateEnable);

  assert_instant_trip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gateEnable && uvloOk && (trip.ov || trip.vddOv)) |=> !gateEnable);

  assert_cause_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (faultCause != CAUSE_NONE && !causeClear) |=> (faultCause == $past(faultCause)));

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF && !(cycleStrobe && hiccupDone)) |=> !gateEnable);

  assert_clear_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (causeClear && !tripNow) |=> (faultCause == CAUSE_NONE));

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int LONG_DEB = 2048,
  parameter int OC_DEB   = 4,
  parameter int SUP_W    = 8,
  parameter int ON_CODE  = 145,
  parameter int OFF_CODE = 85,
  parameter int TEMP_W   = 8,
  parameter int OTP_TRIP = 150,
  parameter int OTP_HYS  = 30,
  parameter int HIC_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cycleStrobe,
  input  logic              uvFlag,
  input  logic              ovFlag,
  input  logic              vddOvFlag,
  input  logic              ocFlag,
  input  logic              maxDutyFlag,
  input  logic [SUP_W-1:0]  supplyCode,
  input  logic [TEMP_W-1:0] tempCode,
  input  logic [HIC_W-1:0]  hiccupLen,
  input  logic              causeClear,
  output logic              gateEnable,
  output logic [2:0]        faultCause
);

  ctl_s  ctl;
  trip_s trip;
  logic  uvloOk;
  logic  hiccupDone;

  hiccup_datapath #(
    .LONG_DEB (LONG_DEB),
    .OC_DEB   (OC_DEB),
    .SUP_W    (SUP_W),
    .ON_CODE  (ON_CODE),
    .OFF_CODE (OFF_CODE),
    .TEMP_W   (TEMP_W),
    .OTP_TRIP (OTP_TRIP),
    .OTP_HYS  (OTP_HYS),
    .HIC_W    (HIC_W)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycleStrobe (cycleStrobe),
    .uvFlag      (uvFlag),
    .ovFlag      (ovFlag),
    .vddOvFlag   (vddOvFlag),
    .ocFlag      (ocFlag),
    .maxDutyFlag (maxDutyFlag),
    .supplyCode  (supplyCode),
    .tempCode    (tempCode),
    .hiccupLen   (hiccupLen),
    .ctl         (ctl),
    .trip        (trip),
    .uvloOk      (uvloOk),
    .hiccupDone  (hiccupDone)
  );

  hiccup_control u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycleStrobe (cycleStrobe),
    .causeClear  (causeClear),
    .trip        (trip),
    .uvloOk      (uvloOk),
    .hiccupDone  (hiccupDone),
    .ctl         (ctl),
    .gateEnable  (gateEnable),
    .faultCause  (faultCause)
  );

endmodule

// File: tb/hiccup_supervisor_tb.sv
module hiccup_supervisor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LONG = 64;
  localparam int OCN  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycleStrobe = 1'b0;
  logic       uvFlag = 1'b0, ovFlag = 1'b0, vddOvFlag = 1'b0, ocFlag = 1'b0, maxDutyFlag = 1'b0;
  logic [7:0] supplyCode = 8'd0;
  logic [7:0] tempCode = 8'd25;
  logic [7:0] hiccupLen = 8'd3;
  logic       causeClear = 1'b0;
  logic       gateEnable;
  logic [2:0] faultCause;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_supervisor #(.LONG_DEB(LONG), .OC_DEB(OCN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cycleStrobe(cycleStrobe),
    .uvFlag(uvFlag), .ovFlag(ovFlag), .vddOvFlag(vddOvFlag), .ocFlag(ocFlag),
    .maxDutyFlag(maxDutyFlag), .supplyCode(supplyCode), .tempCode(tempCode),
    .hiccupLen(hiccupLen), .causeClear(causeClear),
    .gateEnable(gateEnable), .faultCause(faultCause)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycleStrobe = 1'b1;
      @(negedge clk) cycleStrobe = 1'b0;
    end
  endtask

  task automatic clearCause();
    @(negedge clk) causeClear = 1'b1;
    @(negedge clk) causeClear = 1'b0;
  endtask

  // strobes needed until the gate comes back
  task automatic recover(output int used);
    uvFlag = 0; ovFlag = 0; vddOvFlag = 0; ocFlag = 0; maxDutyFlag = 0;
    used = 0;
    while (!gateEnable && used < 600) begin
      strobe(1);
      used++;
    end
  endtask

  function automatic int expRestart(input int len);
    return (len < 1) ? 1 : len;
  endfunction

  function automatic bit expLongTrip(input int runLen);
    return runLen >= LONG;
  endfunction

  initial begin
    int used;
    void'($urandom(32'd1234));
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R11 reset state
    check("R11 gate after reset", gateEnable, 0);
    check("R11 cause after reset", faultCause, 0);

    // R5 lockout rise
    supplyCode = 8'd120; tick(4);
    check("R5 below on-threshold stays locked", gateEnable, 0);
    supplyCode = 8'd145; tick(4);
    check("R5 equal to on-threshold stays locked", gateEnable, 0);
    supplyCode = 8'd150; tick(4);
    check("R5 enabled above on-threshold", gateEnable, 1);

    // R1 long debounce boundary
    uvFlag = 1; strobe(LONG - 1);
    check("R1 one strobe short", gateEnable, 1);
    strobe(1);
    check("R1 trip on last strobe", gateEnable, 0);
    check("R9 cause uv", faultCause, 1);
    uvFlag = 0;

    // R7 hiccup length
    strobe(2);
    check("R7 still off before hiccup ends", gateEnable, 0);
    strobe(1);
    check("R7 restart after hiccupLen strobes", gateEnable, 1);
    check("R9 cause held", faultCause, 1);
    clearCause();
    check("R10 cause cleared", faultCause, 0);

    // R8 broken run does not trip
    uvFlag = 1; strobe(LONG - 10);
    uvFlag = 0; strobe(1);
    uvFlag = 1; strobe(LONG - 10);
    check("R8 broken uv run does not trip", gateEnable, 1);
    uvFlag = 0; tick(1);

    // R3 over-current short debounce
    ocFlag = 1; strobe(OCN - 1);
    check("R3 oc one strobe short", gateEnable, 1);
    strobe(1);
    check("R3 oc trips", gateEnable, 0);
    check("R9 cause oc", faultCause, 4);
    recover(used);
    check("R7 recover after oc", gateEnable, 1);
    clearCause();

    // R2 maximum duty
    maxDutyFlag = 1; strobe(LONG - 1);
    check("R2 max duty one short", gateEnable, 1);
    strobe(1);
    check("R2 max duty trips", gateEnable, 0);
    check("R9 cause max duty", faultCause, 5);
    recover(used);
    clearCause();

    // R4 instant ov, then retry while still present
    @(negedge clk) ovFlag = 1;
    @(negedge clk);
    check("R4 ov drops gate next clock", gateEnable, 0);
    check("R9 cause ov", faultCause, 2);
    strobe(3);
    tick(2);
    check("R7 retry re-trips while ov stays", gateEnable, 0);
    check("R9 cause held over retry", faultCause, 2);
    recover(used);
    check("R7 non-latching after ov gone", gateEnable, 1);
    clearCause();

    // R9 priority, R4 supply over-voltage
    @(negedge clk) begin ovFlag = 1; vddOvFlag = 1; end
    @(negedge clk);
    check("R4 supply ov drops gate", gateEnable, 0);
    check("R9 priority supply-ov over ov", faultCause, 3);
    recover(used);
    clearCause();

    // R6 over-temperature hysteresis
    tempCode = 8'd149; tick(4);
    check("R6 below trip keeps running", gateEnable, 1);
    tempCode = 8'd150; tick(3);
    check("R6 hot trips", gateEnable, 0);
    check("R9 cause hot", faultCause, 6);
    tempCode = 8'd125;
    strobe(3); tick(3);
    check("R6 hot held inside hysteresis", gateEnable, 0);
    tempCode = 8'd120; tick(2);
    recover(used);
    check("R6 released at trip minus hysteresis", gateEnable, 1);
    clearCause();

    // R5 lockout fall with hysteresis
    supplyCode = 8'd90; tick(4);
    check("R5 above off-threshold keeps running", gateEnable, 1);
    supplyCode = 8'd80; tick(4);
    check("R5 below off-threshold locks", gateEnable, 0);
    supplyCode = 8'd100; tick(4);
    check("R5 band after lockout stays locked", gateEnable, 0);
    supplyCode = 8'd150; tick(4);
    check("R5 relock released", gateEnable, 1);
    check("R5 lockout records no cause", faultCause, 0);

    // random runs around the long boundary with random hiccup lengths
    for (int t = 0; t < 16; t++) begin
      int runLen;
      bit tripped;
      hiccupLen = 8'($urandom_range(1, 6));
      runLen = $urandom_range(LONG - 6, LONG);
      tripped = expLongTrip(runLen);
      uvFlag = 1; strobe(runLen);
      check("R1 random run length", gateEnable, tripped ? 0 : 1);
      uvFlag = 0;
      if (tripped) begin
        check("R9 random cause uv", faultCause, 1);
        recover(used);
        check("R7 random hiccup length", used, expRestart(int'(hiccupLen)));
        clearCause();
      end else begin
        tick(1);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule